// File: doc/BRIEF.md
# Framed FIFO SPI Master Engine

This block is the data path of a memory-mapped SPI master. Software programs a word length of 1 to 32 bits, a number of words per frame, a bit order and a clock mode. It loads up to 64 left-justified words into a transmit queue, then enables the serial clock, the receiver and the transmitter. Finally it raises a frame-start enable. The engine clocks out the programmed number of words. Serial clock edges are paced by a tick input from an external divider. Received words are collected into a 64-entry receive queue, left-justified in the same way. At the end of the frame, two end-of-frame status flags are set, and an interrupt is raised if enabled.

Each control enable reads back as set only once the engine has taken it in, so software can poll for it before the next step. Chip select is driven outside the block. A transmit-dummy option sends zero bits without consuming the transmit queue. An idle-tristate option releases the data-out pin between frames, for three-wire wiring.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset, every readable register returns zero, `irq` is low and `sck` is low.
- R2: Transmit mode register 2 (offset 0x04) keeps the word length minus one in bits 28:24 and the word count minus one in bits 23:16, and reads back what was written. A frame shifts exactly that many words of that many bits. Words written to offset 0x50 and read from offset 0x60 are left-justified: a word of N bits occupies bits 31 down to 32-N, and the bits below it read as zero.
- R3: By default the most significant bit is shifted first. Bit 24 of mode register 1 (0x00 for transmit, 0x10 for receive) selects least-significant-bit first.
- R4: Control (0x28) bit 30 gives the clock polarity. Bit 27 is the transmit-edge select, and the clock phase is bit 27 when bit 30 is 1, and the inverse of bit 27 when bit 30 is 0. In phase 0 data are sampled on the leading clock edge and changed on the trailing edge. In phase 1 they are changed on the leading edge and sampled on the trailing edge.
- R5: Control enables sit at bit 15 (serial clock), bit 14 (frame start), bit 9 (transmit) and bit 8 (receive). Each reads back at its new value only after it has been applied, one clock after the write.
- R6: A frame starts only when the applied frame-start enable rises while the applied serial-clock and transmit enables are both set.
- R7: With transmit mode 2 bit 0 set, the frame shifts out zero bits and the transmit queue is left untouched.
- R8: At frame end, status (0x40) bit 23 is set, and bit 7 is also set if receive was enabled. Writing 1 to a status bit clears it.
- R9: `irq` is high while any status bit is set together with the same bit of the interrupt-enable register (0x44). It stays high until the status bit or the enable bit is cleared.
- R10: A read of offset 0x60 when the receive queue is empty returns zero. A write to offset 0x50 when the transmit queue already holds 64 words is dropped.
- R11: When control bits 23:22 equal binary 10, `mosi_oe` is low outside a frame and high during one. Otherwise `mosi_oe` is always high.
- R12: Outside a frame, `sck` rests at the level of control bit 30, and it returns to that level when a frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at 0x60) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sck_tick | input | 1 | One-cycle pulse from the divider; each pulse is one clock half-period |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that software leaves the mode and control configuration unchanged while a frame is running. They also assume a programmed word count of at most 64 and at least one system clock between `sck_tick` pulses. The stimulus writes the configuration only between frames and waits for the interrupt before it touches any register. It drives `sck_tick` every second clock and ties `miso` to `mosi`. With that wiring, every transmitted word comes back in the receive queue, and the expected receive data can be predicted from the bench's own model of the transmit queue.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  localparam logic [7:0] OFS_TXM1 = 8'h00;
  localparam logic [7:0] OFS_TXM2 = 8'h04;
  localparam logic [7:0] OFS_RXM1 = 8'h10;
  localparam logic [7:0] OFS_RXM2 = 8'h14;
  localparam logic [7:0] OFS_CTRL = 8'h28;
  localparam logic [7:0] OFS_STAT = 8'h40;
  localparam logic [7:0] OFS_IEN  = 8'h44;
  localparam logic [7:0] OFS_TXD  = 8'h50;
  localparam logic [7:0] OFS_RXD  = 8'h60;

  // index of each enable inside the 4-bit request/applied vectors
  localparam int EN_SCK = 3;
  localparam int EN_FSE = 2;
  localparam int EN_TXE = 1;
  localparam int EN_RXE = 0;

  // Mirror the N-bit left-justified field of w end for end; result is left-justified.
  function automatic logic [31:0] flip_lj(input logic [31:0] w, input logic [5:0] n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i < int'(n)) r[31-i] = w[32-int'(n)+i];
    return r;
  endfunction

  // Clock phase recovered from polarity and the transmit-edge select bit.
  function automatic logic derive_cpha(input logic cpol, input logic tedg);
    return cpol ? tedg : ~tedg;
  endfunction
endpackage

// File: rtl/spi_eng_fifo.sv
`timescale 1ns/1ps
module spi_eng_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             do_push, do_pop;

  assign do_push = push && (cnt < (AW+1)'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign dout    = (cnt != '0) ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH)); // R10
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int WORDS_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [5:0]         bits,
  input  logic [WORDS_W-1:0] words,
  input  logic               tx_lsb,
  input  logic               rx_lsb,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               dummy,
  input  logic               rx_on,
  input  logic [31:0]        tx_head,
  output logic               tx_pop,
  output logic               rx_push,
  output logic [31:0]        rx_word,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               busy,
  output logic               done
);
  localparam int EDGE_W = WORDS_W + 7;

  logic [31:0]        tx_sr, rx_sr, rx_cat, rx_lj, next_word;
  logic [5:0]         bitcnt;
  logic [WORDS_W-1:0] wcnt;
  logic [EDGE_W-1:0]  ecnt, total;
  logic               sck_q, need_load, fresh;
  logic               lead, capture, launch, last_bit, load_mid, begin_frame;

  assign total       = EDGE_W'(2 * int'(bits) * int'(words));
  assign begin_frame = start && !busy;
  assign lead        = ~ecnt[0];
  assign capture     = busy && tick && (lead ^ cpha);
  assign launch      = busy && tick && !(lead ^ cpha);
  assign last_bit    = (bitcnt == bits - 6'd1);
  assign load_mid    = launch && need_load;
  assign done        = busy && tick && (ecnt == total - 1'b1);
  assign next_word   = dummy ? 32'd0 : (tx_lsb ? flip_lj(tx_head, bits) : tx_head);
  assign tx_pop      = (begin_frame || load_mid) && !dummy;

  assign rx_cat  = {rx_sr[30:0], miso};
  assign rx_lj   = rx_cat << (6'd32 - bits);
  assign rx_word = rx_lsb ? flip_lj(rx_lj, bits) : rx_lj;
  assign rx_push = capture && last_bit && rx_on;

  assign sck  = busy ? sck_q : cpol;
  assign mosi = tx_sr[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sck_q     <= 1'b0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      bitcnt    <= '0;
      wcnt      <= '0;
      ecnt      <= '0;
      need_load <= 1'b0;
      fresh     <= 1'b0;
    end else if (begin_frame) begin
      busy      <= 1'b1;
      sck_q     <= cpol;
      tx_sr     <= next_word;
      bitcnt    <= '0;
      wcnt      <= '0;
      ecnt      <= '0;
      need_load <= 1'b0;
      fresh     <= cpha;
    end else if (busy && tick) begin
      sck_q <= ~sck_q;
      ecnt  <= ecnt + 1'b1;
      if (capture) begin
        rx_sr <= rx_cat;
        if (last_bit) begin
          bitcnt <= '0;
          wcnt   <= wcnt + 1'b1;
          if (wcnt != words - 1'b1) need_load <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 6'd1;
        end
      end
      if (launch) begin
        if (need_load) begin
          tx_sr     <= next_word;
          need_load <= 1'b0;
        end else if (fresh) begin
          fresh <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[30:0], 1'b0};
        end
      end
      if (done) busy <= 1'b0;
    end
  end

  AST_SCK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sck_q == cpol)); // R12
endmodule

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
module spi_frame_engine
  import spi_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        sck_tick,
  output logic        sck,
  output logic        mosi,
  output logic        mosi_oe,
  input  logic        miso,
  output logic        irq
);
  localparam int WORDS_W = $clog2(FIFO_DEPTH + 1);

  function automatic logic [WORDS_W-1:0] clamp_words(input logic [7:0] c);
    int n;
    n = int'(c) + 1;
    if (n > FIFO_DEPTH) n = FIFO_DEPTH;
    return WORDS_W'(n);
  endfunction

  logic        txm_lsb, rxm_lsb, txm_dummy;
  logic [4:0]  txm_len, rxm_len;
  logic [7:0]  txm_cnt, rxm_cnt;
  logic [15:0] ctl_cfg;
  logic [3:0]  ctl_req, ctl_app;
  logic        fse_prev;
  logic        sts_teof, sts_reof, ien_teof, ien_reof;

  logic        wr_txm1, wr_txm2, wr_rxm1, wr_rxm2, wr_ctrl, wr_stat, wr_ien, wr_txd, rd_rxd;
  logic        frame_start, frame_done, busy;
  logic        tx_pop, rx_push, cpol, cpha;
  logic [31:0] tx_head, rx_word, rx_dout, ctrl_rd;
  logic [5:0]  bits;
  logic [WORDS_W-1:0] words;

  assign wr_txm1 = wr_en && (addr == OFS_TXM1);
  assign wr_txm2 = wr_en && (addr == OFS_TXM2);
  assign wr_rxm1 = wr_en && (addr == OFS_RXM1);
  assign wr_rxm2 = wr_en && (addr == OFS_RXM2);
  assign wr_ctrl = wr_en && (addr == OFS_CTRL);
  assign wr_stat = wr_en && (addr == OFS_STAT);
  assign wr_ien  = wr_en && (addr == OFS_IEN);
  assign wr_txd  = wr_en && (addr == OFS_TXD);
  assign rd_rxd  = rd_en && (addr == OFS_RXD);

  assign cpol  = ctl_cfg[14];                       // control bit 30
  assign cpha  = derive_cpha(cpol, ctl_cfg[11]);    // control bit 27
  assign bits  = {1'b0, txm_len} + 6'd1;
  assign words = clamp_words(txm_cnt);

  assign frame_start = ctl_app[EN_FSE] && !fse_prev && ctl_app[EN_SCK] && ctl_app[EN_TXE] && !busy;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txm_lsb   <= 1'b0;
      rxm_lsb   <= 1'b0;
      txm_dummy <= 1'b0;
      txm_len   <= '0;
      rxm_len   <= '0;
      txm_cnt   <= '0;
      rxm_cnt   <= '0;
      ctl_cfg   <= '0;
      ctl_req   <= '0;
      ctl_app   <= '0;
      fse_prev  <= 1'b0;
      sts_teof  <= 1'b0;
      sts_reof  <= 1'b0;
      ien_teof  <= 1'b0;
      ien_reof  <= 1'b0;
    end else begin
      if (wr_txm1) txm_lsb <= wdata[24];
      if (wr_rxm1) rxm_lsb <= wdata[24];
      if (wr_txm2) begin
        txm_len   <= wdata[28:24];
        txm_cnt   <= wdata[23:16];
        txm_dummy <= wdata[0];
      end
      if (wr_rxm2) begin
        rxm_len <= wdata[28:24];
        rxm_cnt <= wdata[23:16];
      end
      if (wr_ctrl) begin
        ctl_cfg <= wdata[31:16];
        ctl_req <= {wdata[15], wdata[14], wdata[9], wdata[8]};
      end
      ctl_app  <= ctl_req;
      fse_prev <= ctl_app[EN_FSE];
      if (wr_ien) begin
        ien_teof <= wdata[23];
        ien_reof <= wdata[7];
      end
      if (frame_done) sts_teof <= 1'b1;
      else if (wr_stat && wdata[23]) sts_teof <= 1'b0;
      if (frame_done && ctl_app[EN_RXE]) sts_reof <= 1'b1;
      else if (wr_stat && wdata[7]) sts_reof <= 1'b0;
    end
  end

  assign irq     = (sts_teof && ien_teof) || (sts_reof && ien_reof);
  assign mosi_oe = !((ctl_cfg[7:6] == 2'b10) && !busy);   // control bits 23:22
  assign ctrl_rd = {ctl_cfg, ctl_app[EN_SCK], ctl_app[EN_FSE], 4'b0,
                    ctl_app[EN_TXE], ctl_app[EN_RXE], 8'b0};

  always_comb begin
    case (addr)
      OFS_TXM1: rdata = {7'b0, txm_lsb, 24'b0};
      OFS_TXM2: rdata = {3'b0, txm_len, txm_cnt, 15'b0, txm_dummy};
      OFS_RXM1: rdata = {7'b0, rxm_lsb, 24'b0};
      OFS_RXM2: rdata = {3'b0, rxm_len, rxm_cnt, 16'b0};
      OFS_CTRL: rdata = ctrl_rd;
      OFS_STAT: rdata = {8'b0, sts_teof, 15'b0, sts_reof, 7'b0};
      OFS_IEN:  rdata = {8'b0, ien_teof, 15'b0, ien_reof, 7'b0};
      OFS_RXD:  rdata = rx_dout;
      default:  rdata = '0;
    endcase
  end

  spi_eng_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_txd), .din(wdata), .pop(tx_pop), .dout(tx_head)
  );

  spi_eng_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rd_rxd), .dout(rx_dout)
  );

  spi_eng_shifter #(.WORDS_W(WORDS_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(sck_tick), .start(frame_start),
    .bits(bits), .words(words), .tx_lsb(txm_lsb), .rx_lsb(rxm_lsb),
    .cpol(cpol), .cpha(cpha), .dummy(txm_dummy), .rx_on(ctl_app[EN_RXE]),
    .tx_head(tx_head), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .done(frame_done)
  );

  AST_APPLY_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req != ctl_app) |=> (ctl_app == $past(ctl_req))); // R5
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctl_app[EN_SCK]) && $past(ctl_app[EN_TXE]))); // R6
  AST_EOF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> sts_teof); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_stat && !wr_ien) |=> irq); // R9
endmodule

// File: tb/spi_frame_engine_test.sv
`timescale 1ns/1ps
module spi_frame_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        sck, mosi, mosi_oe, irq;
  wire         miso;

  assign miso = mosi;   // loopback
  always #4 clk = ~clk; // 125 MHz

  spi_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_tick(tick), .sck(sck), .mosi(mosi),
    .mosi_oe(mosi_oe), .miso(miso), .irq(irq)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;
  int unsigned txmodel[$];  // bench model of the transmit queue
  int unsigned sbq[$];      // expected serial words
  int unsigned rxexp[$];    // expected received words
  bit mon_active = 0, mon_cpol = 0, mon_cpha = 0, mon_lsb = 0;
  int mon_n = 8;

  function automatic int unsigned mask_n(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_en(int pos, bit val);
    logic [31:0] c;
    bit seen = 0;
    rd(8'h28, c);
    c[pos] = val;
    wr(8'h28, c);
    for (int i = 0; i < 10 && !seen; i++) begin
      rd(8'h28, c);
      seen = (c[pos] == val);
    end
    check(seen, "R5 enable readback", c, {31'b0, val} << pos);
  endtask

  task automatic push_words(int n, int nbits, int unsigned seed);
    for (int k = 0; k < n; k++) begin
      int unsigned v;
      v = (seed ^ (k * 32'h9E37_79B9)) & mask_n(nbits);
      wr(8'h50, v << (32 - nbits));
      if (txmodel.size() < 64) txmodel.push_back(v);
    end
  endtask

  task automatic run_frame(int nbits, int nwords, bit lsb, bit cpol, bit cpha,
                           bit dummy, bit rx_on, bit tristate);
    logic [31:0] d, m2;
    bit tedg;
    int waited;
    tedg = cpol ? cpha : !cpha;
    mon_cpol = cpol; mon_cpha = cpha; mon_lsb = lsb; mon_n = nbits;
    wr(8'h00, {7'b0, lsb, 24'b0});
    wr(8'h10, {7'b0, lsb, 24'b0});
    m2 = ((nbits - 1) << 24) | ((nwords - 1) << 16) | dummy;
    wr(8'h04, m2);
    wr(8'h14, m2 & 32'hFFFF_FFFE);
    rd(8'h04, d);
    check(d == m2, "R2 mode2 readback", d, m2);
    wr(8'h28, (cpol << 30) | (cpol << 28) | (tedg << 27) | ((!tedg) << 26) | (tristate ? (2 << 22) : 0));
    wr(8'h44, 32'h0080_0080);
    check(sck == cpol, "R12 idle level", sck, cpol);
    check(mosi_oe == !tristate, "R11 idle oe", mosi_oe, !tristate);
    for (int k = 0; k < nwords; k++) begin
      int unsigned v;
      v = 0;
      if (!dummy && txmodel.size() > 0) v = txmodel.pop_front();
      sbq.push_back(v);
      if (rx_on) rxexp.push_back(v);
    end
    set_en(15, 1'b1);
    if (rx_on) set_en(8, 1'b1);
    set_en(9, 1'b1);
    mon_active = 1;
    set_en(14, 1'b1);
    if (tristate) begin
      repeat (2) @(negedge clk);
      check(mosi_oe == 1'b1, "R11 oe in frame", mosi_oe, 1);
    end
    waited = 0;
    while (!irq && waited < 40000) begin @(negedge clk); waited++; end
    check(irq == 1'b1, "R9 irq at frame end", irq, 1);
    rd(8'h40, d);
    check(d == (32'h0080_0000 | (rx_on ? 32'h80 : 0)), "R8 status", d, 32'h0080_0000 | (rx_on ? 32'h80 : 0));
    check(sbq.size() == 0, "R2 word count", sbq.size(), 0);
    sbq.delete();
    mon_active = 0;
    wr(8'h44, 32'h0);
    check(irq == 1'b0, "R9 masked", irq, 0);
    wr(8'h44, 32'h0080_0080);
    check(irq == 1'b1, "R9 unmasked", irq, 1);
    while (rxexp.size() > 0) begin
      int unsigned e;
      e = rxexp.pop_front() << (32 - nbits);
      rd(8'h60, d);
      check(d == e, "R2 R3 received word", d, e);
    end
    wr(8'h40, 32'h0080_0080);
    rd(8'h40, d);
    check(d == 0, "R8 clear", d, 0);
    check(irq == 1'b0, "R9 cleared", irq, 0);
    set_en(14, 1'b0);
    set_en(9, 1'b0);
    if (rx_on) set_en(8, 1'b0);
    set_en(15, 1'b0);
    check(sck == cpol, "R12 rest level", sck, cpol);
    check(mosi_oe == !tristate, "R11 oe after frame", mosi_oe, !tristate);
  endtask

  // scoreboard monitor: rebuild words from mosi at the sampling edges
  initial begin
    logic prev_sck = 1'b0;
    logic [31:0] acc = '0;
    int nb = 0;
    forever begin
      @(negedge clk);
      if (mon_active && sck != prev_sck && ((sck != mon_cpol) == (mon_cpha == 0))) begin
        acc = {acc[30:0], mosi};
        nb++;
        if (nb == mon_n) begin
          int unsigned got, exp;
          got = 0;
          for (int i = 0; i < mon_n; i++) got[i] = mon_lsb ? acc[mon_n-1-i] : acc[i];
          if (sbq.size() == 0) check(0, "R2 extra word", got, 0);
          else begin
            exp = sbq.pop_front();
            check(got == exp, "R3 R4 serial word", got, exp);
          end
          nb = 0; acc = '0;
        end
      end
      if (!mon_active) begin nb = 0; acc = '0; end
      prev_sck = sck;
    end
  end

  initial forever begin @(negedge clk); tick = ~tick; end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h28, d); check(d == 0, "R1 control", d, 0);
    rd(8'h40, d); check(d == 0, "R1 status", d, 0);
    rd(8'h04, d); check(d == 0, "R1 mode2", d, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(sck == 0, "R1 sck", sck, 0);
    // R10 empty receive queue
    rd(8'h60, d); check(d == 0, "R10 empty read", d, 0);
    // several word sizes, bit orders and clock modes
    push_words(4, 8, 32'h5A);       run_frame(8, 4, 0, 0, 0, 0, 1, 0);
    push_words(3, 16, 32'hC3A5);    run_frame(16, 3, 1, 0, 1, 0, 1, 0);
    push_words(2, 32, 32'h8BAD_F00D); run_frame(32, 2, 0, 1, 0, 0, 1, 1);
    push_words(5, 12, 32'h3C1);     run_frame(12, 5, 1, 1, 1, 0, 1, 0);
    // R7 dummy frame leaves the queue alone, then the next frame sends it
    push_words(2, 8, 32'h81);
    run_frame(8, 3, 0, 0, 0, 1, 1, 0);
    run_frame(8, 2, 0, 0, 0, 0, 1, 0);
    // R6 frame start without serial clock enable: no frame
    set_en(9, 1'b1);
    set_en(14, 1'b1);
    repeat (100) @(negedge clk);
    rd(8'h40, d); check(d == 0, "R6 no start", d, 0);
    check(irq == 0, "R6 no irq", irq, 0);
    set_en(14, 1'b0);
    set_en(9, 1'b0);
    // R10 full transmit queue drops the 65th word
    push_words(65, 8, 32'h37);
    run_frame(8, 64, 0, 0, 0, 0, 1, 0);
    run_frame(8, 1, 0, 0, 0, 0, 1, 0);   // model queue is empty: expects zero
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule